// File: doc/BRIEF.md
# Multiplexer-wired gate fabric

This block is a logic array whose wiring comes entirely from a configuration word. It forms the combinational part of a small synchronous machine. A grid of `ROWS` x `COLS` cells each computes AND, OR or NOT, or drives zero. Each cell operand comes from a select multiplexer. The candidate sources for an operand are two constants, the primary inputs, the present-state bits and the cells of the column just to the left. Further multiplexers choose what drives each state flip-flop input and each primary output. Their sources are the primary inputs and any cell of the array.

A search process outside the block writes a candidate genome into the block through a parallel load port. It then steps the machine with input sequences and scores the outputs. The block also reports how many cells actually reach a flip-flop input or a primary output, either directly or through other cells. This count lets the search reward smaller circuits.

Top module: `mux_gate_fabric`

## Requirements
- R1: An active-high synchronous `rst` clears the state flip-flops and the whole configuration to zero. With an all-zero configuration every output follows primary input 0 and `used_cnt` is 0.
- R2: `cfg_word` is captured at a rising edge only while `cfg_load` is high. While `cfg_load` is low, the configuration, and therefore the circuit's behaviour, is unaffected by `cfg_word`.
- R3: The 2-bit cell function code selects the cell output: 0 is A AND B, 1 is A OR B, 2 is NOT A (operand B has no effect), and 3 is a constant 0.
- R4: Operand select indices: 0 is constant 0, 1 is constant 1, 2..2+N_IN-1 are the primary inputs, the next N_ST are the state bits, and the next ROWS are the rows of the left-hand column. In column 0 that last range, and any index of OP_SRC or more, reads as 0.
- R5: Sink select indices: 0..N_IN-1 are the primary inputs, and N_IN+k is cell k, where k = col*ROWS+row. Any index of N_IN+ROWS*COLS or more reads as 0.
- R6: Each state bit takes its sink multiplexer value at every rising edge outside reset. The primary outputs are combinational in the inputs, the state and the configuration.
- R7: Configuration layout, LSB first: cell k occupies CELL_W bits from k*CELL_W. Within it are the function in bits [1:0], operand A in the next OP_W bits and operand B in the OP_W bits after that. Next come N_ST state selects, then N_OUT output selects, each SK_W bits.
- R8: `used_cnt` is the number of cells whose output reaches a state input or a primary output, either directly or through the operands that the receiving cell's function reads.
- R9: When a configuration is loaded at the same edge that the state advances, the new state is computed with the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for state and configuration |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration capture enable |
| cfg_word | input | CFG_W | Genome: all function and select fields |
| pin | input | N_IN | Primary inputs |
| pout | output | N_OUT | Primary outputs |
| state | output | N_ST | Present-state flip-flops |
| used_cnt | output | CNT_W | Number of cells reaching a sink |

## Verification
A configuration capture and a state step can fall on the same rising edge. The bench provokes this with directed cases and with random cycles in which `cfg_load` is raised while the state keeps evolving. In the directed case, one genome drives state bit 0 high and the next drives it low. The reference model advances the state with the configuration held before the edge and applies the new genome only afterwards, so the captured state bit must show the old circuit's result.

// File: rtl/mgf_pkg.sv
package mgf_pkg;
   localparam int FN_W = 2;
   typedef enum logic [FN_W-1:0] {
      FN_AND  = 2'd0,
      FN_OR   = 2'd1,
      FN_NOT  = 2'd2,
      FN_ZERO = 2'd3
   } cell_fn_e;
endpackage

// File: rtl/mgf_pick.sv
module mgf_pick #(
   parameter int SRC_N = 4,
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [SRC_N-1:0] src,
   output logic             y
);
   localparam logic [SEL_W:0] LIMIT = SRC_N[SEL_W:0];

   generate
      if ((1 << SEL_W) < SRC_N) begin : g_bad
         $error("mgf_pick: select too narrow for source count");
      end
   endgenerate

   always_comb begin
      if ({1'b0, sel} < LIMIT) y = src[sel];
      else                     y = 1'b0;
   end
endmodule

// File: rtl/mgf_cell.sv
module mgf_cell
   import mgf_pkg::*;
#(
   parameter int SRC_N = 4,
   parameter int SEL_W = 2
) (
   input  cell_fn_e         fn_i,
   input  logic [SEL_W-1:0] sel_a,
   input  logic [SEL_W-1:0] sel_b,
   input  logic [SRC_N-1:0] src,
   output logic             y
);
   logic opnd_a, opnd_b;

   mgf_pick #(.SRC_N(SRC_N), .SEL_W(SEL_W)) u_pick_a (
      .sel(sel_a), .src(src), .y(opnd_a));
   mgf_pick #(.SRC_N(SRC_N), .SEL_W(SEL_W)) u_pick_b (
      .sel(sel_b), .src(src), .y(opnd_b));

   always_comb begin
      unique case (fn_i)
         FN_AND:  y = opnd_a & opnd_b;
         FN_OR:   y = opnd_a | opnd_b;
         FN_NOT:  y = ~opnd_a;
         default: y = 1'b0;
      endcase
   end
endmodule

// File: rtl/mgf_usage.sv
module mgf_usage #(
   parameter int N_IN  = 1,
   parameter int N_ST  = 3,
   parameter int N_OUT = 1,
   parameter int ROWS  = 3,
   parameter int COLS  = 3,
   localparam int CELLS  = ROWS * COLS,
   localparam int OP_SRC = 2 + N_IN + N_ST + ROWS,
   localparam int OP_W   = $clog2(OP_SRC),
   localparam int SK_SRC = N_IN + CELLS,
   localparam int SK_W   = $clog2(SK_SRC),
   localparam int CELL_W = 2 + 2 * OP_W,
   localparam int ARR_W  = CELLS * CELL_W,
   localparam int CFG_W  = ARR_W + (N_ST + N_OUT) * SK_W,
   localparam int CNT_W  = $clog2(CELLS + 1)
) (
   input  logic [CFG_W-1:0] cfg,
   output logic [CNT_W-1:0] used_cnt
);
   localparam int LEFT_LO = 2 + N_IN + N_ST;

   logic [CELLS-1:0] reach;

   always_comb begin
      reach = '0;
      for (int j = 0; j < N_ST + N_OUT; j++) begin
         int s;
         s = int'(cfg[ARR_W + j*SK_W +: SK_W]);
         if (s >= N_IN && s < SK_SRC) reach[s - N_IN] = 1'b1;
      end
      for (int c = COLS - 1; c >= 1; c--) begin
         for (int r = 0; r < ROWS; r++) begin
            int k, fn, a, b;
            k  = c * ROWS + r;
            fn = int'(cfg[k*CELL_W +: 2]);
            a  = int'(cfg[k*CELL_W + 2 +: OP_W]);
            b  = int'(cfg[k*CELL_W + 2 + OP_W +: OP_W]);
            if (reach[k]) begin
               if (fn != 3 && a >= LEFT_LO && a < OP_SRC)
                  reach[(c-1)*ROWS + a - LEFT_LO] = 1'b1;
               if (fn < 2 && b >= LEFT_LO && b < OP_SRC)
                  reach[(c-1)*ROWS + b - LEFT_LO] = 1'b1;
            end
         end
      end
   end

   always_comb begin
      int n;
      n = 0;
      for (int k = 0; k < CELLS; k++) n += int'(reach[k]);
      used_cnt = CNT_W'(n);
   end
endmodule

// File: rtl/mux_gate_fabric.sv
module mux_gate_fabric
   import mgf_pkg::*;
#(
   parameter int N_IN  = 1,
   parameter int N_ST  = 3,
   parameter int N_OUT = 1,
   parameter int ROWS  = 3,
   parameter int COLS  = 3,
   localparam int CELLS  = ROWS * COLS,
   localparam int OP_SRC = 2 + N_IN + N_ST + ROWS,
   localparam int OP_W   = $clog2(OP_SRC),
   localparam int SK_SRC = N_IN + CELLS,
   localparam int SK_W   = $clog2(SK_SRC),
   localparam int CELL_W = 2 + 2 * OP_W,
   localparam int ARR_W  = CELLS * CELL_W,
   localparam int CFG_W  = ARR_W + (N_ST + N_OUT) * SK_W,
   localparam int CNT_W  = $clog2(CELLS + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_load,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic [N_IN-1:0]  pin,
   output logic [N_OUT-1:0] pout,
   output logic [N_ST-1:0]  state,
   output logic [CNT_W-1:0] used_cnt
);
   generate
      if (N_IN < 1 || N_ST < 1 || N_OUT < 1 || ROWS < 1 || COLS < 1) begin : g_bad
         $error("mux_gate_fabric: every dimension must be at least 1");
      end
   endgenerate

   logic [CFG_W-1:0]  cfg_q;
   logic [N_ST-1:0]   st_q;
   logic [N_ST-1:0]   d_nxt;
   logic [CELLS-1:0]  cell_y;
   logic [SK_SRC-1:0] sk_src;

   assign sk_src = {cell_y, pin};

   // cell grid: one source vector per column, one cell per row
   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [OP_SRC-1:0] op_src;
      if (c == 0) begin : g_first
         assign op_src = {{ROWS{1'b0}}, st_q, pin, 2'b10};
      end else begin : g_inner
         assign op_src = {cell_y[(c-1)*ROWS +: ROWS], st_q, pin, 2'b10};
      end
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         localparam int K    = c * ROWS + r;
         localparam int BASE = K * CELL_W;
         mgf_cell #(.SRC_N(OP_SRC), .SEL_W(OP_W)) u_cell (
            .fn_i (cell_fn_e'(cfg_q[BASE +: 2])),
            .sel_a(cfg_q[BASE + 2 +: OP_W]),
            .sel_b(cfg_q[BASE + 2 + OP_W +: OP_W]),
            .src  (op_src),
            .y    (cell_y[K]));
      end
   end

   // sink multiplexers: state inputs first, then primary outputs
   for (genvar j = 0; j < N_ST + N_OUT; j++) begin : g_sink
      logic pick;
      mgf_pick #(.SRC_N(SK_SRC), .SEL_W(SK_W)) u_pick (
         .sel(cfg_q[ARR_W + j*SK_W +: SK_W]),
         .src(sk_src),
         .y  (pick));
      if (j < N_ST) begin : g_st
         assign d_nxt[j] = pick;
      end else begin : g_out
         assign pout[j - N_ST] = pick;
      end
   end

   mgf_usage #(.N_IN(N_IN), .N_ST(N_ST), .N_OUT(N_OUT), .ROWS(ROWS), .COLS(COLS)) u_usage (
      .cfg(cfg_q), .used_cnt(used_cnt));

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
         st_q  <= '0;
      end else begin
         st_q <= d_nxt;
         if (cfg_load) cfg_q <= cfg_word;
      end
   end

   assign state = st_q;

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (st_q == '0 && cfg_q == '0));
   a_r2_cfg_held: assert property (@(posedge clk) disable iff (rst)
      (!$past(cfg_load) && !$past(rst)) |-> $stable(cfg_q));
   a_r2_cfg_taken: assert property (@(posedge clk) disable iff (rst)
      ($past(cfg_load) && !$past(rst)) |-> cfg_q == $past(cfg_word));
   a_r6_state_steps: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> st_q == $past(d_nxt));
   a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
      used_cnt <= CNT_W'(CELLS));
endmodule

// File: tb/mux_gate_fabric_tb.sv
`timescale 1ns/1ps
module mux_gate_fabric_tb;
   localparam int N_IN = 1, N_ST = 3, N_OUT = 1, ROWS = 3, COLS = 3;
   localparam int CELLS  = ROWS * COLS;
   localparam int OP_SRC = 2 + N_IN + N_ST + ROWS;
   localparam int OP_W   = $clog2(OP_SRC);
   localparam int SK_SRC = N_IN + CELLS;
   localparam int SK_W   = $clog2(SK_SRC);
   localparam int CELL_W = 2 + 2 * OP_W;
   localparam int ARR_W  = CELLS * CELL_W;
   localparam int CFG_W  = ARR_W + (N_ST + N_OUT) * SK_W;
   localparam int CNT_W  = $clog2(CELLS + 1);
   localparam int LEFT_LO = 2 + N_IN + N_ST;

   logic clk = 1'b0;
   logic rst, cfg_load;
   logic [CFG_W-1:0] cfg_word;
   logic [N_IN-1:0]  pin;
   logic [N_OUT-1:0] pout;
   logic [N_ST-1:0]  state;
   logic [CNT_W-1:0] used_cnt;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [CFG_W-1:0] cfg_m;
   logic [N_ST-1:0]  st_m;

   always #10 clk = ~clk;

   mux_gate_fabric #(.N_IN(N_IN), .N_ST(N_ST), .N_OUT(N_OUT), .ROWS(ROWS), .COLS(COLS)) u_dut (
      .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
      .pin(pin), .pout(pout), .state(state), .used_cnt(used_cnt));

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic opv(int idx, int c, logic [N_IN-1:0] p, logic [N_ST-1:0] s,
                                logic [CELLS-1:0] cy);
      if (idx == 0) return 1'b0;
      if (idx == 1) return 1'b1;
      if (idx < 2 + N_IN) return p[idx-2];
      if (idx < LEFT_LO) return s[idx-2-N_IN];
      if (idx < OP_SRC && c > 0) return cy[(c-1)*ROWS + idx - LEFT_LO];
      return 1'b0;
   endfunction

   function automatic void model(input logic [CFG_W-1:0] cf, input logic [N_IN-1:0] p,
                                 input logic [N_ST-1:0] s, output logic [N_ST-1:0] dn,
                                 output logic [N_OUT-1:0] po, output int nused);
      logic [CELLS-1:0] cy, us;
      logic v;
      cy = '0; us = '0;
      for (int c = 0; c < COLS; c++)
         for (int r = 0; r < ROWS; r++) begin
            int k, fn;
            logic a, b;
            k  = c*ROWS + r;
            fn = int'(cf[k*CELL_W +: 2]);
            a  = opv(int'(cf[k*CELL_W+2 +: OP_W]), c, p, s, cy);
            b  = opv(int'(cf[k*CELL_W+2+OP_W +: OP_W]), c, p, s, cy);
            cy[k] = (fn == 0) ? (a & b) : (fn == 1) ? (a | b) : (fn == 2) ? ~a : 1'b0;
         end
      for (int j = 0; j < N_ST + N_OUT; j++) begin
         int sel;
         sel = int'(cf[ARR_W + j*SK_W +: SK_W]);
         v = (sel < N_IN) ? p[sel] : (sel < SK_SRC) ? cy[sel-N_IN] : 1'b0;
         if (sel >= N_IN && sel < SK_SRC) us[sel-N_IN] = 1'b1;
         if (j < N_ST) dn[j] = v; else po[j-N_ST] = v;
      end
      for (int c = COLS-1; c > 0; c--)
         for (int r = 0; r < ROWS; r++) begin
            int k, fn, a, b;
            k  = c*ROWS + r;
            fn = int'(cf[k*CELL_W +: 2]);
            a  = int'(cf[k*CELL_W+2 +: OP_W]);
            b  = int'(cf[k*CELL_W+2+OP_W +: OP_W]);
            if (us[k] && fn != 3 && a >= LEFT_LO && a < OP_SRC) us[(c-1)*ROWS+a-LEFT_LO] = 1'b1;
            if (us[k] && fn < 2 && b >= LEFT_LO && b < OP_SRC) us[(c-1)*ROWS+b-LEFT_LO] = 1'b1;
         end
      nused = $countones(us);
   endfunction

   function automatic logic [CFG_W-1:0] set_cell(logic [CFG_W-1:0] cf, int k, int fn, int a, int b);
      cf[k*CELL_W +: 2]           = 2'(fn);
      cf[k*CELL_W+2 +: OP_W]      = OP_W'(a);
      cf[k*CELL_W+2+OP_W +: OP_W] = OP_W'(b);
      return cf;
   endfunction

   function automatic logic [CFG_W-1:0] set_sink(logic [CFG_W-1:0] cf, int j, int sel);
      cf[ARR_W + j*SK_W +: SK_W] = SK_W'(sel);
      return cf;
   endfunction

   function automatic logic [CFG_W-1:0] rnd_cfg();
      logic [CFG_W-1:0] w;
      for (int i = 0; i < CFG_W; i++) w[i] = 1'($urandom % 2);
      return w;
   endfunction

   // one cycle: drive, compare combinational outputs and state, then advance model
   task automatic step(input string tag, input logic [N_IN-1:0] p, input logic ld,
                       input logic [CFG_W-1:0] w);
      logic [N_ST-1:0] dn;
      logic [N_OUT-1:0] po;
      int nu;
      @(negedge clk);
      pin = p; cfg_load = ld; cfg_word = w;
      #1;
      model(cfg_m, p, st_m, dn, po, nu);
      chk({tag, " pout"}, int'(pout), int'(po));
      chk({tag, " state"}, int'(state), int'(st_m));
      chk("R8 used_cnt", int'(used_cnt), nu);
      @(posedge clk);
      st_m = dn;
      if (ld) cfg_m = w;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [CFG_W-1:0] c0, c1;
      void'($urandom(32'd1234));
      rst = 1; cfg_load = 0; cfg_word = '0; pin = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      cfg_m = '0; st_m = '0;
      #1;
      // R1: cleared state and configuration
      chk("R1 state", int'(state), 0);
      chk("R1 used_cnt", int'(used_cnt), 0);
      chk("R1 pout", int'(pout), 0);
      step("R1", 1'b1, 1'b0, '0);
      #2; chk("R1 pout follows pin0", int'(pout), 1);

      // R3 and R7: NOT on cell 0 reads pin0, operand B has no effect
      c0 = set_sink(set_cell('0, 0, 2, 2, 1), N_ST, N_IN + 0);
      step("R7 load", 1'b0, 1'b1, c0);
      step("R3 not", 1'b0, 1'b0, '0);
      #2; chk("R3 not of 0", int'(pout), 1);
      c1 = set_sink(set_cell('0, 0, 2, 2, 0), N_ST, N_IN + 0);
      step("R3 load", 1'b1, 1'b1, c1);
      step("R3 not b ignored", 1'b1, 1'b0, '0);
      #2; chk("R3 not of 1", int'(pout), 0);

      // R4 and R5: column-0 left range and out-of-range selects read 0
      c0 = set_cell('0, 0, 1, LEFT_LO, (1 << OP_W) - 1);
      c0 = set_cell(c0, 1, 1, 1, 0);
      c0 = set_cell(c0, ROWS, 0, LEFT_LO + 1, 1);
      c0 = set_sink(c0, N_ST, N_IN + ROWS);
      c0 = set_sink(c0, 0, N_IN + 0);
      c0 = set_sink(c0, 1, (1 << SK_W) - 1);
      step("R4 load", 1'b0, 1'b1, c0);
      step("R4 chain", 1'b1, 1'b0, '0);
      #2; chk("R4 left col cell", int'(pout), 1);
      chk("R8 chain count", int'(used_cnt), 3);
      step("R5 oor", 1'b0, 1'b0, '0);
      #2; chk("R5 state0 from cell0", int'(state[0]), 0);
      chk("R5 state1 oor", int'(state[1]), 0);

      // R6: state bit 0 samples pin0, bit 1 takes NOT of state bit 0
      c0 = set_sink(set_cell('0, 0, 2, 2 + N_IN, 0), 0, 0);
      c0 = set_sink(c0, 1, N_IN + 0);
      step("R6 load", 1'b0, 1'b1, c0);
      for (int i = 0; i < 8; i++) step("R6", N_IN'(i % 3 == 0), 1'b0, rnd_cfg());

      // R9: load at the same edge as a step uses the old genome
      c0 = set_sink(set_cell('0, 0, 1, 1, 0), 0, N_IN + 0);
      c1 = set_sink(set_cell('0, 0, 0, 0, 0), 0, N_IN + 0);
      step("R9 load a", 1'b0, 1'b1, c0);
      step("R9 swap", 1'b0, 1'b1, c1);
      #2; chk("R9 old genome result", int'(state[0]), 1);
      step("R9 after", 1'b0, 1'b0, '0);
      #2; chk("R9 new genome result", int'(state[0]), 0);

      // R2: words offered without cfg_load have no effect
      for (int i = 0; i < 10; i++) step("R2 hold", N_IN'($urandom), 1'b0, rnd_cfg());

      // random genomes and stimulus
      for (int i = 0; i < 400; i++) begin
         logic ld;
         ld = ($urandom % 8 == 0);
         step("R6 random", N_IN'($urandom), ld, rnd_cfg());
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule